// File: doc/BRIEF.md
# LIN Wakeup and Low-Power Controller

This block handles entry into and exit from low power for a serial port that runs either as a plain UART or as a LIN node. Software sets a power-down flag through a small register port. While that flag is set, the block watches the receive line. A high-to-low transition on it ends power-down and raises a sticky interrupt, but only when the wakeup interrupt is enabled. With the enable clear, the node stays asleep whatever the line does.

To wake the rest of the bus, software preloads the byte 0xF0 into the transmit data register. It then sets the wakeup-generate request while power-down is active. The block sends that byte as an 8N1 frame, one bit per baud tick. The start bit and the four low data bits drive the line dominant for five bit times, and the upper four bits and the stop bit return it recessive for five more. A low-time counter treats eleven or more dominant ticks as a synch break, which withdraws the request. Clearing the reset-release bit returns all dynamic state to idle.

Top module: `lin_wake_ctl`

## Requirements
- R1: Register map: address 0 is control ([0] reset release, [1] wakeup interrupt enable, [2] power-down, [3] wakeup request); address 1 is transmit data; address 2 is status ([0] wakeup flag, write 1 to clear; [1] transmitter busy). The power-down bit takes a written value only while reset release already reads 1.
- R2: While power-down and the interrupt enable are both 1, a falling edge on `rx_i` clears power-down and sets the wakeup flag within 4 clock cycles. The input passes a two-flop synchroniser first.
- R3: With the interrupt enable at 0, a low level on `rx_i` leaves power-down set and the flag clear.
- R4: The wakeup flag drives `wake_irq` and stays set until a status write with bit 0 at 1. A status write with bit 0 at 0 leaves it set.
- R5: A write to the wakeup request bit takes effect only when reset release and power-down both already read 1. At any other time it is ignored.
- R6: A 0-to-1 change of the request bit starts one frame at the next baud tick. The frame is a start bit of 0, the eight data bits LSB first, then a stop bit of 1, each held for one tick interval. For data 0xF0 this gives exactly 5 dominant bit times followed by 5 recessive ones.
- R7: `tx_o` is 1 whenever no frame is in progress.
- R8: `rx_i` held low for 11 or more consecutive baud ticks clears the wakeup request. A shorter low period does not.
- R9: Writing reset release to 0 clears power-down, the request, the wakeup flag and any frame in progress, and `tx_o` returns to 1.
- R10: After `rst_n` is low, all registers read 0, `tx_o` is 1 and `wake_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| rx_i | input | 1 | Serial receive line, 0 is dominant |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| tx_o | output | 1 | Serial transmit line, 1 is recessive |
| wake_irq | output | 1 | Wakeup interrupt, sticky |

## Verification
The frame path is driven with random bytes and the 0xF0 wakeup byte. Random bytes show whether every bit position leaves in LSB-first order. The wakeup byte confirms the five-dominant, five-recessive shape. Receive-line pulses are applied with the interrupt enable chosen at random, which separates a true wakeup from an ignored edge. Low periods of 9 and 12 ticks sit on either side of the 11-tick break threshold. Request writes made outside power-down, and a reset release dropped mid-frame, show that the gating and the abort both work.

// File: rtl/lin_wake_ctl.sv
module lin_wake_ctl #(
  parameter int DW       = 8,
  parameter int AW       = 2,
  parameter int BRK_BITS = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          rx_i,
  input  logic          baud_tick,
  output logic          tx_o,
  output logic          wake_irq
);
  localparam int FW  = DW + 2;
  localparam int BCW = $clog2(FW);
  localparam int KCW = $clog2(BRK_BITS + 1);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_DATA = AW'(1);
  localparam logic [AW-1:0] A_STAT = AW'(2);

  logic rel, ie, pd, genwu, flag, go, busy;
  logic rx_s1, rx_s2, rx_d;
  logic [DW-1:0]  txd;
  logic [FW-1:0]  sh;
  logic [BCW-1:0] bcnt;
  logic [KCW-1:0] lcnt;

  wire wr_ctrl = reg_we && reg_addr == A_CTRL;
  wire wr_data = reg_we && reg_addr == A_DATA;
  wire wr_stat = reg_we && reg_addr == A_STAT;
  wire fall    = rx_d & ~rx_s2;
  wire wake    = pd & ie & fall;
  wire brk     = baud_tick & ~rx_s2 & (lcnt == KCW'(BRK_BITS - 1));
  wire gw_set  = wr_ctrl & rel & pd & reg_wdata[3] & ~genwu;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {rx_s1, rx_s2, rx_d} <= 3'b111;
    else        {rx_s1, rx_s2, rx_d} <= {rx_i, rx_s1, rx_s2};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rel <= 1'b0;
      ie  <= 1'b0;
      txd <= '0;
    end else begin
      if (wr_ctrl) begin
        rel <= reg_wdata[0];
        ie  <= reg_wdata[1];
      end
      if (wr_data) txd <= reg_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       pd <= 1'b0;
    else if (!rel)    pd <= 1'b0;
    else if (wake)    pd <= 1'b0;
    else if (wr_ctrl) pd <= reg_wdata[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             genwu <= 1'b0;
    else if (!rel)          genwu <= 1'b0;
    else if (brk)           genwu <= 1'b0;
    else if (wr_ctrl && pd) genwu <= reg_wdata[3];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  flag <= 1'b0;
    else if (!rel)               flag <= 1'b0;
    else if (wake)               flag <= 1'b1;
    else if (wr_stat && reg_wdata[0]) flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  go <= 1'b0;
    else if (!rel)               go <= 1'b0;
    else if (gw_set)             go <= 1'b1;
    else if (baud_tick && !busy) go <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '1;
      bcnt <= '0;
    end else if (!rel) begin
      busy <= 1'b0;
      sh   <= '1;
    end else if (baud_tick) begin
      if (busy) begin
        if (bcnt == BCW'(FW - 1)) busy <= 1'b0;
        else begin
          sh   <= {1'b1, sh[FW-1:1]};
          bcnt <= bcnt + 1'b1;
        end
      end else if (go) begin
        busy <= 1'b1;
        sh   <= {1'b1, txd, 1'b0};
        bcnt <= '0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      lcnt <= '0;
    else if (baud_tick) begin
      if (rx_s2)                     lcnt <= '0;
      else if (lcnt != KCW'(BRK_BITS)) lcnt <= lcnt + 1'b1;
    end

  assign tx_o     = ~busy | sh[0];
  assign wake_irq = flag;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[3:0] = {genwu, pd, ie, rel};
      A_DATA:  reg_rdata      = txd;
      A_STAT:  reg_rdata[1:0] = {busy, flag};
      default: reg_rdata      = '0;
    endcase
  end
endmodule

module lin_wake_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic rel,
  input logic ie,
  input logic pd,
  input logic genwu,
  input logic flag,
  input logic fall,
  input logic brk,
  input logic wr_ctrl,
  input logic wr_stat,
  input logic wdata0,
  input logic tx_o
);
  assert_wake_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && pd && ie && fall) |=> (!pd && flag));
  assert_asleep_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && pd && !ie && !wr_ctrl) |=> pd);
  assert_irq_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && rel && !(wr_stat && wdata0)) |=> flag);
  assert_req_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!genwu && !(rel && pd)) |=> !genwu);
  assert_break_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> !genwu);
  assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rel |=> (!pd && !genwu && !flag && tx_o));
endmodule

bind lin_wake_ctl lin_wake_ctl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .rel(rel), .ie(ie), .pd(pd), .genwu(genwu),
  .flag(flag), .fall(fall), .brk(brk), .wr_ctrl(wr_ctrl), .wr_stat(wr_stat),
  .wdata0(reg_wdata[0]), .tx_o(tx_o)
);

// File: tb/test_lin_wake_ctl.sv
module test_lin_wake_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic rx_i = 1'b1, baud_tick = 1'b0, tx_o, wake_irq;
  int total = 0, bad = 0, tcnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tcnt      <= (tcnt == 7) ? 0 : tcnt + 1;
    baud_tick <= (tcnt == 7);
  end

  lin_wake_ctl i_lin_wake_ctl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_i(rx_i),
    .baud_tick(baud_tick), .tx_o(tx_o), .wake_irq(wake_irq)
  );

  function automatic logic frame_bit(input logic [7:0] d, input int i);
    if (i == 0) return 1'b0;
    if (i == 9) return 1'b1;
    return d[i-1];
  endfunction

  function automatic logic [7:0] ctrl_val(input bit rel, ie, pd, req);
    return {4'b0, req, pd, ie, rel};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic grab_frame(input logic [7:0] d);
    int wait_n = 0;
    int dom = 0;
    while (tx_o && wait_n < 100) begin
      @(negedge clk);
      wait_n++;
    end
    chk("R6 frame start", int'(tx_o), 0);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      chk("R6 frame bit", int'(tx_o), int'(frame_bit(d, i)));
      if (i < 5 && !tx_o) dom++;
      repeat (8) @(negedge clk);
    end
    if (d == 8'hF0) chk("R6 dominant bit times", dom, 5);
    chk("R7 idle after frame", int'(tx_o), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h1d5a));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, v); chk("R10 ctrl reset", v, 0);
    rd(2'd1, v); chk("R10 data reset", v, 0);
    rd(2'd2, v); chk("R10 status reset", v, 0);
    chk("R10 tx idle", int'(tx_o), 1);
    chk("R10 irq low", int'(wake_irq), 0);

    wr(2'd0, 8'h04);
    rd(2'd0, v); chk("R1 pd blocked while held", v, 0);
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h09);
    rd(2'd0, v); chk("R5 request ignored awake", v, 8'h01);
    repeat (40) @(negedge clk);
    chk("R7 no frame without request", int'(tx_o), 1);
    wr(2'd0, 8'h05);
    rd(2'd0, v); chk("R1 pd set", v, 8'h05);

    for (int it = 0; it < 12; it++) begin
      logic [7:0] d;
      bit ie;
      d  = (it == 0) ? 8'hF0 : 8'($urandom);
      ie = (it < 2) ? bit'(it) : bit'($urandom % 2);
      wr(2'd1, d);
      wr(2'd0, ctrl_val(1, ie, 1, 0));
      wr(2'd0, ctrl_val(1, ie, 1, 1));
      rd(2'd0, v); chk("R5 request accepted", v, ctrl_val(1, ie, 1, 1));
      grab_frame(d);
      rx_i = 1'b0;
      repeat (5) @(negedge clk);
      rd(2'd0, v);
      if (ie) chk("R2 wake clears pd", v, ctrl_val(1, 1, 0, 1));
      else    chk("R3 pd kept", v, ctrl_val(1, 0, 1, 1));
      rd(2'd2, v); chk(ie ? "R2 flag set" : "R3 flag clear", v, ie);
      chk("R4 irq pin", int'(wake_irq), ie);
      rx_i = 1'b1;
      repeat (4) @(negedge clk);
      if (ie) begin
        wr(2'd2, 8'h00);
        chk("R4 irq held", int'(wake_irq), 1);
        wr(2'd2, 8'h01);
        chk("R4 irq cleared", int'(wake_irq), 0);
      end
      wr(2'd0, 8'h00);
      rd(2'd0, v); chk("R9 ctrl cleared", v, 0);
      wr(2'd0, 8'h01);
    end

    wr(2'd1, 8'h55);
    wr(2'd0, 8'h05);
    wr(2'd0, 8'h0D);
    rx_i = 1'b0;
    repeat (72) @(negedge clk);
    rx_i = 1'b1;
    repeat (10) @(negedge clk);
    rd(2'd0, v); chk("R8 short low keeps request", v, 8'h0D);
    rx_i = 1'b0;
    repeat (100) @(negedge clk);
    rd(2'd0, v); chk("R8 break clears request", v, 8'h05);
    rx_i = 1'b1;
    repeat (100) @(negedge clk);

    wr(2'd1, 8'h00);
    wr(2'd0, 8'h0D);
    wr(2'd0, 8'h05);
    rd(2'd0, v); chk("R5 request written low", v, 8'h05);
    wr(2'd0, 8'h0D);
    repeat (40) @(negedge clk);
    chk("R6 zero byte dominant", int'(tx_o), 0);
    wr(2'd0, 8'h00);
    @(negedge clk);
    chk("R9 frame aborted", int'(tx_o), 1);
    rd(2'd2, v); chk("R9 busy cleared", v, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule